// File: doc/BRIEF.md
# Log-Domain Approximate Multiplier and Divider

This block gives a cheap estimate of the product or the quotient of two unsigned W-bit words. It does no true arithmetic: each operand is reduced to the index of its highest set bit, the two indices are summed (multiply, with W taken off so the product stays on a W-bit scale) or subtracted (divide), and a W-bit word is rebuilt from the resulting index. In plain mode the rebuilt word has only that bit set. In dense mode every second bit below it is set as well, which brings the estimate closer to the mean of the values it stands for.

Operands enter through a valid/ready handshake and the answer leaves through a registered valid/ready output. A two-state holding machine controls the output register. In EMPTY the register is free. In FULL it holds an answer that has not yet been taken. EMPTY goes to FULL on an accepted operation. FULL goes to EMPTY when the answer is taken and no new operation arrives in that cycle. FULL stays in FULL while the answer waits, or when an answer is taken and a new one is accepted in the same cycle. A zero divisor yields all ones and a sticky error flag.

Top module: `logmd_unit`

## Requirements
- R1: Multiply with both operands nonzero and p = msb(a) + msb(b) − W ≥ 0 returns a word with bit p set. In plain mode (alt_fill = 0) no other bit is set. msb(x) is the index of the highest set bit, counting from 0 at the least significant bit.
- R2: Multiply with both operands nonzero and p < 0 returns zero. For W = 8, 0x10 × 0x08 gives 0 and 0x10 × 0x10 gives 0x01.
- R3: Multiply with either operand zero returns zero.
- R4: Divide with both operands nonzero uses p = msb(a) − msb(b). A negative p returns zero.
- R5: Divide with a zero dividend and a nonzero divisor returns zero.
- R6: Divide by zero returns all ones and raises div_err. This holds even when the dividend is also zero. div_err then stays high until the next accepted operation, including while no answer is pending.
- R7: With alt_fill = 1, the result has bits p, p−2, p−4 and so on set, down to bit 1 or bit 0.
- R8: An operation accepted on a clock edge (in_valid and in_ready both high) appears on result with out_valid high after that edge. While out_valid is high and out_ready is low, result and div_err hold still.
- R9: in_ready is high whenever no answer is pending or out_ready is high, and low otherwise.
- R10: A synchronous active-high rst clears out_valid, result and div_err.
- R11: The result index never exceeds W−1. All-ones operands multiply to bit W−2. An all-ones dividend over 1 gives bit W−1. An index above W−1 would clamp to W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid |
| in_ready | output | 1 | Block can accept an operation |
| a | input | W | Multiplicand or dividend |
| b | input | W | Multiplier or divisor |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| alt_fill | input | 1 | 1 = alternating-bit rebuild, 0 = single bit |
| out_valid | output | 1 | result holds an answer |
| out_ready | input | 1 | Consumer takes the answer |
| result | output | W | Approximate product or quotient |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The hardest case to reach is an accept and a take in the same cycle while the consumer stalls at random. Those cycles decide whether in_ready, the holding state and the sticky flag stay consistent. The bench drives out_ready from a random source while operations stream in back to back, and it checks every cycle against a queue model. Directed runs cover the index boundaries (p = −1, p = 0, and the largest indices), and a divide-by-zero followed by idle cycles checks that the flag persists.

// File: rtl/logmd_pkg.sv
`timescale 1ns/1ps
package logmd_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;
endpackage

// File: rtl/logmd_msb.sv
`timescale 1ns/1ps
// Index of the highest set bit; returns 0 for a zero word (callers screen zero).
module logmd_msb #(
    parameter int W = 8,
    localparam int LW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  x,
    output logic [LW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (x[i]) idx = LW'(i);
        end
    end
endmodule

// File: rtl/logmd_fill.sv
`timescale 1ns/1ps
// Rebuilds a W-bit word from a signed bit index.
module logmd_fill #(
    parameter int W  = 8,
    parameter int PW = 5
) (
    input  logic signed [PW-1:0] pos,
    input  logic                 alt,
    output logic [W-1:0]         pat
);
    localparam logic signed [PW-1:0] TOP_IDX = PW'(W - 1);

    logic signed [PW-1:0] clamp_pos;

    // index above the word saturates to the top bit
    always_comb clamp_pos = (pos > TOP_IDX) ? TOP_IDX : pos;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic signed [PW-1:0] BIT_IDX = PW'(i);
        logic signed [PW-1:0] gap;
        assign gap    = clamp_pos - BIT_IDX;
        assign pat[i] = alt ? (!gap[PW-1] && !gap[0]) : (gap == '0);
    end
endmodule

// File: rtl/logmd_unit.sv
`timescale 1ns/1ps
module logmd_unit
    import logmd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         op_div,
    input  logic         alt_fill,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] result,
    output logic         div_err
);
    localparam int LW = (W > 1) ? $clog2(W) : 1;
    localparam int PW = LW + 2;
    localparam logic signed [PW-1:0] W_S = PW'(W);

    hold_state_e state_q, state_d;
    logic [LW-1:0] lead_a, lead_b;
    logic signed [PW-1:0] bit_pos;
    logic [W-1:0] fill_pat, res_d, res_q;
    logic err_d, err_q;
    logic accept;

    logmd_msb #(.W(W)) u_msb_a (.x(a), .idx(lead_a));
    logmd_msb #(.W(W)) u_msb_b (.x(b), .idx(lead_b));

    always_comb begin
        if (op_div)
            bit_pos = $signed({2'b00, lead_a}) - $signed({2'b00, lead_b});
        else
            bit_pos = $signed({2'b00, lead_a}) + $signed({2'b00, lead_b}) - W_S;
    end

    logmd_fill #(.W(W), .PW(PW)) u_fill (
        .pos (bit_pos),
        .alt (alt_fill),
        .pat (fill_pat)
    );

    // operand screening: divide-by-zero first, then zero operands
    always_comb begin
        err_d = 1'b0;
        if (op_div && (b == '0)) begin
            res_d = '1;
            err_d = 1'b1;
        end else if ((a == '0) || (b == '0)) begin
            res_d = '0;
        end else begin
            res_d = fill_pat;
        end
    end

    // holding state machine
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        accept    = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            err_q <= 1'b0;
        end else if (accept) begin
            res_q <= res_d;
            err_q <= err_d;
        end
    end

    assign result  = res_q;
    assign div_err = err_q;

    // R8: accepted work shows up one edge later
    assert_accept_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R8: stalled answer does not move
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(div_err)));

    // R9: a free register always takes work
    assert_free_ready_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R6: error flag always comes with the all-ones word
    assert_err_pattern_R6: assert property (@(posedge clk) disable iff (rst)
        div_err |-> (result == '1));

    // R1: plain rebuild never sets two bits
    assert_plain_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !alt_fill && !(op_div && b == '0)) |=> $onehot0(result));

    // R10: reset empties the output
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && !div_err && result == '0));
endmodule

// File: tb/logmd_unit_bench.sv
`timescale 1ns/1ps
module logmd_unit_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, op_div = 1'b0, alt_fill = 1'b0, out_ready = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic in_ready, out_valid, div_err;
    logic [W-1:0] result;

    int total = 0, bad = 0;
    bit done = 0, running = 0, rand_rdy = 0;
    logic [W-1:0] q_res[$];
    string q_tag[$];
    logic err_m = 1'b0;

    always #2.5 clk = ~clk;

    logmd_unit #(.W(W)) u_logmd_unit (
        .clk, .rst, .in_valid, .in_ready, .a, .b, .op_div, .alt_fill,
        .out_valid, .out_ready, .result, .div_err
    );

    function automatic int msb(logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y, logic dv, logic al);
        logic [W-1:0] r = '0;
        int p;
        if (dv && y == '0) return '1;
        if (x == '0 || y == '0) return '0;
        p = dv ? msb(x) - msb(y) : msb(x) + msb(y) - W;
        if (p < 0) return '0;
        if (p > W - 1) p = W - 1;
        if (!al) r[p] = 1'b1;
        else for (int k = p; k >= 0; k -= 2) r[k] = 1'b1;
        return r;
    endfunction

    function automatic string tag_of(logic [W-1:0] x, logic [W-1:0] y, logic dv, logic al);
        int p;
        if (dv && y == '0) return "R6";
        if (x == '0 || y == '0) return dv ? "R5" : "R3";
        if (x == '1) return "R11";
        if (al) return "R7";
        p = dv ? msb(x) - msb(y) : msb(x) + msb(y) - W;
        if (dv) return "R4";
        return (p < 0) ? "R2" : "R1";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference comparison on every cycle
    always @(negedge clk) begin
        if (running && !rst) begin
            chk("R9", 32'(in_ready), 32'(q_res.size() == 0 || out_ready));
            chk("R8", 32'(out_valid), 32'(q_res.size() != 0));
            if (out_valid && q_res.size() != 0) chk(q_tag[0], 32'(result), 32'(q_res[0]));
            chk("R6", 32'(div_err), 32'(err_m));
            if (out_valid && out_ready && q_res.size() != 0) begin
                void'(q_res.pop_front());
                void'(q_tag.pop_front());
            end
            if (in_valid && in_ready) begin
                q_res.push_back(model(a, b, op_div, alt_fill));
                q_tag.push_back(tag_of(a, b, op_div, alt_fill));
                err_m = op_div && (b == '0);
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (rand_rdy) out_ready = 1'($urandom % 2);
    end

    task automatic issue(logic [W-1:0] x, logic [W-1:0] y, logic dv, logic al);
        bit hs;
        in_valid = 1'b1; a = x; b = y; op_div = dv; alt_fill = al;
        forever begin
            @(negedge clk);
            hs = in_ready;
            @(posedge clk); #1;
            if (hs) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        q_res.delete(); q_tag.delete(); err_m = 1'b0;
        @(negedge clk);
        chk("R10", 32'(out_valid), 0);
        chk("R10", 32'(result), 0);
        chk("R10", 32'(div_err), 0);
        chk("R9", 32'(in_ready), 1);
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        running = 1;
        // R1 / R2 boundaries and R3
        issue(8'h80, 8'h80, 0, 0);
        issue(8'h10, 8'h10, 0, 0);
        issue(8'h10, 8'h08, 0, 0);
        issue(8'h00, 8'h55, 0, 0);
        issue(8'h55, 8'h00, 0, 1);
        // R11 and R7 at the top of the word
        issue(8'hFF, 8'hFF, 0, 0);
        issue(8'hFF, 8'hFF, 0, 1);
        issue(8'hFF, 8'h01, 1, 0);
        issue(8'hFF, 8'h01, 1, 1);
        issue(8'h30, 8'h02, 1, 1);
        // R4 and R5
        issue(8'h05, 8'h40, 1, 0);
        issue(8'h40, 8'h40, 1, 0);
        issue(8'h00, 8'h03, 1, 0);
        // R6: flag persists through idle cycles, cleared by the next op
        issue(8'h05, 8'h00, 1, 0);
        idle(4);
        issue(8'h00, 8'h00, 1, 1);
        idle(2);
        issue(8'h20, 8'h04, 0, 0);
        idle(2);
        // R8 / R9 under a stalled consumer
        out_ready = 1'b0;
        issue(8'h44, 8'h21, 0, 1);
        in_valid = 1'b1; a = 8'h09; b = 8'h03; op_div = 1'b1; alt_fill = 1'b0;
        idle(4);
        in_valid = 1'b0;
        out_ready = 1'b1;
        idle(3);
        // R10 mid-run with the flag set
        issue(8'h11, 8'h00, 1, 0);
        idle(1);
        do_reset();
        // random stream with random back-pressure
        rand_rdy = 1;
        for (int n = 0; n < 400; n++) begin
            issue(W'($urandom), ($urandom % 8 == 0) ? '0 : W'($urandom >> ($urandom % W)),
                  1'($urandom % 2), 1'($urandom % 2));
        end
        rand_rdy = 0;
        out_ready = 1'b1;
        idle(6);
        chk("R8", 32'(q_res.size()), 0);
        running = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule